// File: doc/BRIEF.md
# Instruction Argument Address Generator

This block is the front end of a 16-bit processor pipeline. It fetches the instruction word addressed by its instruction counter and resolves the effective argument N for that instruction. It then hands the instruction and N to an external execute stage and waits for that stage to finish. An external decoder looks at the instruction word and reports its argument class, and says whether the word is the modify instruction.

A normal argument starts from a register or from an in-line word that follows the instruction. The pending modifier value is added to it. A base register may be added for indexing, and one level of indirection may follow. A short argument is a signed 6-bit immediate plus the modifier. A skip flag, set by the execute stage, cancels the next instruction together with its in-line word. The modifier lives for exactly one following instruction, and only the modify instruction can extend it. A memory response may report an error. That error abandons the current instruction and discards the modifier.

Instruction fields (fixed): C = ir[2:0] and B = ir[5:3] select registers 1 to 7, where 0 means absent. D = ir[9]. The short immediate magnitude is ir[5:0], and ir[9] gives its sign. The class input is 0 for none, 1 for normal and 2 for short.

Top module: `arg_addr_gen`

## Requirements
- R1: Each instruction is read from memory at address IC. On a successful read, the word appears on `ir` and IC advances by one.
- R2: If the instruction read returns an error, MOD and the modifier count become 0, IC is unchanged, and the read is retried.
- R3: While the skip flag is set, the next fetched instruction is not executed and the flag clears. IC advances one extra step if that instruction is class normal with C = 0.
- R4: For class normal with C nonzero, N = register[C] + MOD, modulo 2^16.
- R5: For class normal with C = 0, the word at IC is read, N = word + MOD, and IC advances once more.
- R6: When B is nonzero, register[B] is added to N, modulo 2^16, before any indirection.
- R7: When D is set on a normal argument, N is replaced by the memory word at address N.
- R8: For class short, N = MOD + ir[5:0], or MOD − ir[5:0] when ir[9] is 1, with no memory access.
- R9: A class-none instruction goes to execute with N = 0 and makes no extra memory access.
- R10: An error on an argument or indirect read abandons the instruction without execution, and MOD and the modifier count become 0.
- R11: When execution completes, a modify instruction loads MOD from `exec_mod_val` and increments the modifier count. Any other instruction clears both.
- R12: On completion, `exec_skip` sets the skip flag and `exec_jump` loads IC from `exec_target`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | output | 1 | Memory read request, held until ack or error |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 16 | Read data, valid with ack |
| mem_ack | input | 1 | Read completed |
| mem_err | input | 1 | Read failed |
| ir | output | 16 | Current instruction word |
| dec_kind | input | 2 | Argument class from decoder: 0 none, 1 normal, 2 short |
| dec_is_mod | input | 1 | Decoder: instruction is the modify instruction |
| rsel_a | output | 3 | Register select for C field |
| rdata_a | input | 16 | Register value for rsel_a |
| rsel_b | output | 3 | Register select for B field |
| rdata_b | input | 16 | Register value for rsel_b |
| exec_go | output | 1 | Instruction and N presented to execute |
| exec_n | output | 16 | Effective argument N |
| exec_done | input | 1 | Execute finished (sampled with exec_go) |
| exec_skip | input | 1 | Set skip flag on completion |
| exec_jump | input | 1 | Load IC on completion |
| exec_target | input | 16 | New IC for a jump |
| exec_mod_val | input | 16 | New MOD for a modify instruction |
| ic | output | 16 | Instruction counter |
| mod | output | 16 | Modifier value |
| modc | output | 4 | Modifier count |
| skip | output | 1 | Skip flag |

## Verification
The bench targets a skip over an instruction with an in-line word. A design that forgets the extra IC step would run that word as an instruction. It also targets errors at each of the three read points. A faulty design there would execute with stale data, keep a stale modifier, or advance IC past the failed word. Chained modify instructions and a modifier followed by a short negative immediate expose wrong modifier lifetime or sign handling. An in-line word plus a base register that wraps past 0xFFFF, followed by indirection, shows whether the index is added before the indirect read.

// File: rtl/arg_addr_gen.sv
module arg_addr_gen #(
  parameter int W = 16,
  parameter int MCW = 4,
  parameter logic [W-1:0] IC_RST = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic           mem_req,
  output logic [W-1:0]   mem_addr,
  input  logic [W-1:0]   mem_rdata,
  input  logic           mem_ack,
  input  logic           mem_err,
  output logic [W-1:0]   ir,
  input  logic [1:0]     dec_kind,
  input  logic           dec_is_mod,
  output logic [2:0]     rsel_a,
  input  logic [W-1:0]   rdata_a,
  output logic [2:0]     rsel_b,
  input  logic [W-1:0]   rdata_b,
  output logic           exec_go,
  output logic [W-1:0]   exec_n,
  input  logic           exec_done,
  input  logic           exec_skip,
  input  logic           exec_jump,
  input  logic [W-1:0]   exec_target,
  input  logic [W-1:0]   exec_mod_val,
  output logic [W-1:0]   ic,
  output logic [W-1:0]   mod,
  output logic [MCW-1:0] modc,
  output logic           skip
);
  localparam logic [1:0] K_NORM  = 2'd1;
  localparam logic [1:0] K_SHORT = 2'd2;
  localparam int TW = 6;

  typedef enum logic [2:0] {S_FETCH, S_DEC, S_ARG, S_IND, S_EXEC} st_t;
  st_t st;

  logic [W-1:0]   ic_q, mod_q, n_q, ir_q;
  logic [MCW-1:0] modc_q;
  logic           p_q;

  wire [2:0]   fc = ir_q[2:0];
  wire [2:0]   fb = ir_q[5:3];
  wire         fd = ir_q[9];
  wire [W-1:0] tmag = {{(W-TW){1'b0}}, ir_q[TW-1:0]};
  wire [W-1:0] tval = fd ? ('0 - tmag) : tmag;
  wire [W-1:0] bidx = (fb != 3'd0) ? rdata_b : '0;
  wire [W-1:0] reg_arg  = rdata_a + mod_q + bidx;
  wire [W-1:0] word_arg = mem_rdata + mod_q + bidx;

  assign rsel_a   = fc;
  assign rsel_b   = fb;
  assign mem_req  = (st == S_FETCH) || (st == S_ARG) || (st == S_IND);
  assign mem_addr = (st == S_IND) ? n_q : ic_q;
  assign exec_go  = (st == S_EXEC);
  assign exec_n   = n_q;
  assign ir       = ir_q;
  assign ic       = ic_q;
  assign mod      = mod_q;
  assign modc     = modc_q;
  assign skip     = p_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_FETCH;
      ic_q   <= IC_RST;
      mod_q  <= '0;
      modc_q <= '0;
      n_q    <= '0;
      ir_q   <= '0;
      p_q    <= 1'b0;
    end else begin
      case (st)
        S_FETCH: begin
          if (mem_err) begin
            mod_q  <= '0;
            modc_q <= '0;
          end else if (mem_ack) begin
            ir_q <= mem_rdata;
            ic_q <= ic_q + 1'b1;
            st   <= S_DEC;
          end
        end
        S_DEC: begin
          if (p_q) begin
            p_q <= 1'b0;
            if (dec_kind == K_NORM && fc == 3'd0) ic_q <= ic_q + 1'b1;
            st <= S_FETCH;
          end else if (dec_kind == K_NORM) begin
            if (fc == 3'd0) begin
              st <= S_ARG;
            end else begin
              n_q <= reg_arg;
              st  <= fd ? S_IND : S_EXEC;
            end
          end else if (dec_kind == K_SHORT) begin
            n_q <= tval + mod_q;
            st  <= S_EXEC;
          end else begin
            n_q <= '0;
            st  <= S_EXEC;
          end
        end
        S_ARG: begin
          if (mem_err) begin
            mod_q  <= '0;
            modc_q <= '0;
            st     <= S_FETCH;
          end else if (mem_ack) begin
            n_q  <= word_arg;
            ic_q <= ic_q + 1'b1;
            st   <= fd ? S_IND : S_EXEC;
          end
        end
        S_IND: begin
          if (mem_err) begin
            mod_q  <= '0;
            modc_q <= '0;
            st     <= S_FETCH;
          end else if (mem_ack) begin
            n_q <= mem_rdata;
            st  <= S_EXEC;
          end
        end
        S_EXEC: begin
          if (exec_done) begin
            if (dec_is_mod) begin
              mod_q  <= exec_mod_val;
              modc_q <= modc_q + 1'b1;
            end else begin
              mod_q  <= '0;
              modc_q <= '0;
            end
            if (exec_skip) p_q <= 1'b1;
            if (exec_jump) ic_q <= exec_target;
            st <= S_FETCH;
          end
        end
        default: st <= S_FETCH;
      endcase
    end
  end

  AST_IC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH && mem_ack && !mem_err) |=> ic == $past(ic) + 1'b1); // R1
  AST_FETCH_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH && mem_err) |=> (mod == '0 && modc == '0 && ic == $past(ic))); // R2
  AST_SKIP_NO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DEC && p_q) |=> (!exec_go && !skip)); // R3
  AST_SHORT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DEC && !p_q && dec_kind == K_SHORT) |=> (exec_go && !mem_req)); // R8
  AST_ARG_ERR_NO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_ARG || st == S_IND) && mem_err) |=> (!exec_go && mod == '0 && modc == '0)); // R10
  AST_MOD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_go && exec_done && !dec_is_mod) |=> (mod == '0 && modc == '0)); // R11
  AST_MODC_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_go && exec_done && dec_is_mod) |=> modc == $past(modc) + 1'b1); // R11
  AST_SKIP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_go && exec_done && exec_skip) |=> skip); // R12
endmodule

// File: tb/arg_addr_gen_test.sv
module arg_addr_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        mem_req, mem_ack, mem_err;
  logic [15:0] mem_addr, mem_rdata, ir;
  logic [1:0]  dec_kind;
  logic        dec_is_mod;
  logic [2:0]  rsel_a, rsel_b;
  logic [15:0] rdata_a, rdata_b;
  logic        exec_go, exec_done, exec_skip, exec_jump;
  logic [15:0] exec_n, exec_target, exec_mod_val, ic, mod;
  logic [3:0]  modc;
  logic        skip;

  logic [15:0] mem [256];
  logic        err_on, err_hit;
  logic [15:0] err_addr;
  logic [15:0] log_n [16];
  logic [15:0] log_ir [16];
  logic [4:0]  nx;
  int nchk = 0, nfail = 0, cyc = 0;

  arg_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err), .ir(ir),
    .dec_kind(dec_kind), .dec_is_mod(dec_is_mod), .rsel_a(rsel_a),
    .rdata_a(rdata_a), .rsel_b(rsel_b), .rdata_b(rdata_b), .exec_go(exec_go),
    .exec_n(exec_n), .exec_done(exec_done), .exec_skip(exec_skip),
    .exec_jump(exec_jump), .exec_target(exec_target),
    .exec_mod_val(exec_mod_val), .ic(ic), .mod(mod), .modc(modc), .skip(skip));

  // register k holds 0x0011*k; decoder: top bits 00 none, 01 normal, 10 short, 11 modify (normal)
  assign rdata_a      = 16'(rsel_a) * 16'h0011;
  assign rdata_b      = 16'(rsel_b) * 16'h0011;
  assign dec_is_mod   = (ir[15:14] == 2'b11);
  assign dec_kind     = dec_is_mod ? 2'd1 : ir[15:14];
  assign exec_done    = exec_go;
  assign exec_skip    = (ir[15:10] == 6'b001111);
  assign exec_jump    = (ir[15:10] == 6'b011111);
  assign exec_target  = exec_n;
  assign exec_mod_val = mod + exec_n;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      mem_ack <= 1'b0; mem_err <= 1'b0; err_hit <= 1'b0; mem_rdata <= '0;
    end else begin
      mem_ack <= 1'b0; mem_err <= 1'b0;
      if (mem_req && !mem_ack && !mem_err) begin
        if (err_on && !err_hit && mem_addr == err_addr) begin
          mem_err <= 1'b1; err_hit <= 1'b1;
        end else begin
          mem_ack <= 1'b1; mem_rdata <= mem[mem_addr[7:0]];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) nx <= '0;
    else if (exec_go) begin
      log_n[nx[3:0]] <= exec_n; log_ir[nx[3:0]] <= ir; nx <= nx + 1'b1;
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 100000) begin
    nchk++; nfail++;
    $display("FAIL watchdog act=%0d exp=<100000", cyc);
    summary();
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] expv);
    nchk++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  task automatic start(input logic [15:0] ea, input logic eo);
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    err_addr = ea; err_on = eo;
    repeat (2) @(posedge clk);
  endtask

  task automatic go();
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic wait_exec(input int k);
    int t = 0;
    while (nx < 5'(k) && t < 300) begin @(negedge clk); t++; end
    if (nx < 5'(k)) chk("exec count", 16'(nx), 16'(k));
    @(negedge clk);
  endtask

  task automatic t_reset();
    start(16'h0, 1'b0);
    go();
    chk("R1 reset ic", ic, 16'h0);
    chk("R11 reset mod", mod, 16'h0);
    chk("R11 reset modc", 16'(modc), 16'h0);
    chk("R12 reset skip", 16'(skip), 16'h0);
    chk("R1 first req", {15'h0, mem_req}, 16'h1);
    chk("R1 first addr", mem_addr, 16'h0);
  endtask

  task automatic t_none();
    start(16'h0, 1'b0); mem[0] = 16'h0001; go();
    wait_exec(1);
    chk("R1 ir", log_ir[0], 16'h0001);
    chk("R9 n zero", log_n[0], 16'h0000);
    chk("R9 ic", ic, 16'h0001);
  endtask

  task automatic t_reg();
    start(16'h0, 1'b0); mem[0] = 16'h4003; go();
    wait_exec(1);
    chk("R4 n", log_n[0], 16'h0033);
    chk("R4 ic", ic, 16'h0001);
  endtask

  task automatic t_inline_index();
    start(16'h0, 1'b0);
    mem[0] = 16'h4000; mem[1] = 16'h0500; mem[2] = 16'h4010; mem[3] = 16'hFFF0;
    go();
    wait_exec(2);
    chk("R5 n", log_n[0], 16'h0500);
    chk("R6 wrap n", log_n[1], 16'h0012);
    chk("R5 ic", ic, 16'h0004);
  endtask

  task automatic t_indirect();
    start(16'h0, 1'b0);
    mem[0] = 16'h4203; mem[8'h33] = 16'hBEEF;
    mem[1] = 16'h4210; mem[2] = 16'h0020; mem[8'h42] = 16'hCAFE;
    go();
    wait_exec(2);
    chk("R7 reg ind", log_n[0], 16'hBEEF);
    chk("R7 R6 inline idx ind", log_n[1], 16'hCAFE);
    chk("R7 ic", ic, 16'h0003);
  endtask

  task automatic t_short_mod();
    start(16'h0, 1'b0);
    mem[0] = 16'h8005; mem[1] = 16'hC001; mem[2] = 16'h8205;
    go();
    wait_exec(1);
    chk("R8 pos", log_n[0], 16'h0005);
    wait_exec(2);
    chk("R11 mod load", mod, 16'h0011);
    chk("R11 modc", 16'(modc), 16'h0001);
    wait_exec(3);
    chk("R8 neg with mod", log_n[2], 16'h000C);
    chk("R11 mod cleared", mod, 16'h0000);
  endtask

  task automatic t_mod_chain();
    start(16'h0, 1'b0);
    mem[0] = 16'hC001; mem[1] = 16'hC001; mem[2] = 16'h8005; mem[3] = 16'h4002;
    go();
    wait_exec(2);
    chk("R4 md n", log_n[1], 16'h0022);
    chk("R11 chain mod", mod, 16'h0033);
    chk("R11 chain modc", 16'(modc), 16'h0002);
    wait_exec(4);
    chk("R8 short+mod", log_n[2], 16'h0038);
    chk("R11 one shot", log_n[3], 16'h0022);
    chk("R11 modc clear", 16'(modc), 16'h0000);
  endtask

  task automatic t_skip();
    start(16'h0, 1'b0);
    mem[0] = 16'h3C00; mem[1] = 16'h4000; mem[2] = 16'h1111; mem[3] = 16'h0001;
    go();
    wait_exec(1);
    chk("R12 skip set", 16'(skip), 16'h0001);
    wait_exec(2);
    chk("R3 skipped inline", log_ir[1], 16'h0001);
    chk("R3 ic", ic, 16'h0004);
    chk("R3 skip cleared", 16'(skip), 16'h0000);
    start(16'h0, 1'b0);
    mem[0] = 16'h3C00; mem[1] = 16'h4001; mem[2] = 16'h0002;
    go();
    wait_exec(2);
    chk("R3 reg arg skip", log_ir[1], 16'h0002);
    chk("R3 reg ic", ic, 16'h0003);
  endtask

  task automatic t_fetch_err();
    start(16'h0001, 1'b1);
    mem[0] = 16'hC001; mem[1] = 16'h4002;
    go();
    wait_exec(2);
    chk("R2 mod dropped", log_n[1], 16'h0022);
    chk("R2 ic", ic, 16'h0002);
  endtask

  task automatic t_arg_err();
    start(16'h0002, 1'b1);
    mem[0] = 16'hC001; mem[1] = 16'h4000; mem[2] = 16'h0009;
    go();
    wait_exec(2);
    chk("R10 arg err next ir", log_ir[1], 16'h0009);
    chk("R10 ic", ic, 16'h0003);
    chk("R10 mod", mod, 16'h0000);
    start(16'h0033, 1'b1);
    mem[0] = 16'h4203; mem[1] = 16'h0007;
    go();
    wait_exec(1);
    chk("R10 ind err next ir", log_ir[0], 16'h0007);
    chk("R10 ind ic", ic, 16'h0002);
  endtask

  task automatic t_jump();
    start(16'h0, 1'b0);
    mem[0] = 16'h7C00; mem[1] = 16'h0040; mem[8'h40] = 16'h0005;
    go();
    wait_exec(1);
    chk("R12 jump ic", ic, 16'h0040);
    wait_exec(2);
    chk("R12 target ir", log_ir[1], 16'h0005);
    chk("R12 ic after", ic, 16'h0041);
  endtask

  initial begin
    t_reset();
    t_none();
    t_reg();
    t_inline_index();
    t_indirect();
    t_short_mod();
    t_mod_chain();
    t_skip();
    t_fetch_err();
    t_arg_err();
    t_jump();
    summary();
  end
endmodule